// File: doc/BRIEF.md
# Peripheral Clock Enable Prescaler

This block derives the clock enables for the peripherals from a single fast bus clock. Every output is a one-cycle enable pulse in the bus clock domain, so no derived clock nets exist. A downstream register treats an enable as its clock edge. The block produces the following enables:

- one enable for each of the two peripheral buses;
- one timer enable for each bus, which follows the rule that a divided bus runs its timers at twice its own rate;
- an ADC enable, derived from the second bus;
- a system tick enable, either at full rate or at one eighth of the rate.

The divide settings are held in two small configuration registers, which are loaded through a single-cycle write port. Each divider takes a new ratio only when its count wraps. A running period is therefore never cut short by a configuration write.

Top module: `periph_clk_prescaler`

## Requirements
- R1: A write with `cfg_wr_en` high stores `cfg_wr_data` on the rising clock edge. At address 0, bits [2:0] set the bus 1 code and bits [5:3] set the bus 2 code. At address 1, bits [2:0] set the ADC code and bit [3] sets the tick source. All other data bits are ignored. After reset, all fields are zero.
- R2: Each bus enable pulses once every P clock cycles. Bus code 0 gives P=1, code 1 gives P=2, code 2 gives P=4, code 3 gives P=8, and codes 4 to 7 give P=16.
- R3: When the bus ratio P is 1, the timer enable of that bus pulses on every clock cycle, the same rate as the bus enable.
- R4: When the bus ratio P is larger than 1, the timer enable of that bus pulses once every P/2 clock cycles, which is twice the bus rate.
- R5: The ADC enable pulses once every N pulses of the bus 2 enable, and only in a cycle where the bus 2 enable is high. ADC code 0 gives N=2, code 1 gives N=4, code 2 gives N=6, code 3 gives N=8, code 4 gives N=12, and codes 5, 6 and 7 give N=16.
- R6: When tick source bit is 1, the system tick enable pulses on every cycle. When the bit is 0, it pulses once every 8 cycles.
- R7: A new ratio takes effect only after the next pulse of that enable. The interval that is running when the write arrives ends with the old ratio, so no interval shorter than the old or the new ratio is produced.
- R8: While `rst_n` is low, all enables are low. After reset, the periods are 1 for each bus and timer, 2 bus 2 pulses for the ADC, and 8 for the tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | 1 | Configuration register select |
| cfg_wr_data | input | 8 | Configuration write data |
| bus1_en | output | 1 | Bus 1 clock enable |
| bus2_en | output | 1 | Bus 2 clock enable |
| tmr1_en | output | 1 | Bus 1 timer clock enable |
| tmr2_en | output | 1 | Bus 2 timer clock enable |
| adc_en | output | 1 | ADC clock enable |
| tick_en | output | 1 | System tick enable |

## Verification
Random configurations fill all fields of both registers, including the data bits that are ignored and the codes above 4 that alias to a ratio. Each enable is then timed pulse to pulse. With these settings, a wrong decode entry, a timer doubling applied at P=1, or a cascade of the ADC from the wrong parent each produce a different period. Directed cases cover the extremes: the ADC at its longest period of 256 cycles, and the ADC codes 6 and 7, which alias to 16. A write placed in the middle of a long bus interval checks that the next interval still has the old length and that the following interval has the new length.

// File: rtl/pcp_pkg.sv
package pcp_pkg;

   localparam int unsigned CODE_W  = 3;
   localparam int unsigned RATIO_W = 5;

   typedef logic [CODE_W-1:0]  code_t;
   typedef logic [RATIO_W-1:0] ratio_t;

   typedef struct packed {
      code_t bus1_code;
      code_t bus2_code;
      code_t adc_code;
      logic  tick_full;
   } pcp_cfg_t;

   function automatic ratio_t bus_ratio(code_t c);
      case (c)
         3'd0:    return ratio_t'(1);
         3'd1:    return ratio_t'(2);
         3'd2:    return ratio_t'(4);
         3'd3:    return ratio_t'(8);
         default: return ratio_t'(16);
      endcase
   endfunction

   function automatic ratio_t tmr_ratio(code_t c);
      ratio_t p;
      p = bus_ratio(c);
      return (p == ratio_t'(1)) ? ratio_t'(1) : (p >> 1);
   endfunction

   function automatic ratio_t adc_ratio(code_t c);
      case (c)
         3'd0:    return ratio_t'(2);
         3'd1:    return ratio_t'(4);
         3'd2:    return ratio_t'(6);
         3'd3:    return ratio_t'(8);
         3'd4:    return ratio_t'(12);
         default: return ratio_t'(16);
      endcase
   endfunction

   function automatic ratio_t tick_ratio(logic full);
      return full ? ratio_t'(1) : ratio_t'(8);
   endfunction

endpackage

// File: rtl/pcp_cfg_regs.sv
module pcp_cfg_regs
   import pcp_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output pcp_cfg_t          cfg
);

   localparam int unsigned BUS2_LSB = CODE_W;
   localparam int unsigned TICK_BIT = CODE_W;

   initial begin
      if (DATA_W < 2 * CODE_W) $fatal(1, "DATA_W too narrow for the bus codes");
   end

   pcp_cfg_t cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (wr_en) begin
         if (!wr_addr) begin
            cfg_q.bus1_code <= wr_data[CODE_W-1:0];
            cfg_q.bus2_code <= wr_data[BUS2_LSB +: CODE_W];
         end else begin
            cfg_q.adc_code  <= wr_data[CODE_W-1:0];
            cfg_q.tick_full <= wr_data[TICK_BIT];
         end
      end
   end

   assign cfg = cfg_q;

endmodule

// File: rtl/pcp_div.sv
module pcp_div #(
   parameter int unsigned RATIO_W    = 5,
   parameter int unsigned INIT_RATIO = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_in,
   input  logic [RATIO_W-1:0] ratio_in,
   output logic               tick_out
);

   initial begin
      if (INIT_RATIO < 1) $fatal(1, "INIT_RATIO must be at least 1");
      if (INIT_RATIO >= (1 << RATIO_W)) $fatal(1, "INIT_RATIO exceeds RATIO_W");
   end

   logic [RATIO_W-1:0] cnt_q;
   logic [RATIO_W-1:0] cur_q;
   logic               wrap;

   assign wrap = tick_in && (cnt_q == cur_q - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         cur_q <= RATIO_W'(INIT_RATIO);
      end else if (tick_in) begin
         if (wrap) begin
            cnt_q <= '0;
            cur_q <= ratio_in;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign tick_out = wrap && rst_n;

endmodule

// File: rtl/periph_clk_prescaler.sv
module periph_clk_prescaler
   import pcp_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned NUM_BUS  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_en,
   input  logic              cfg_wr_addr,
   input  logic [DATA_W-1:0] cfg_wr_data,
   output logic              bus1_en,
   output logic              bus2_en,
   output logic              tmr1_en,
   output logic              tmr2_en,
   output logic              adc_en,
   output logic              tick_en
);

   localparam int unsigned ADC_BUS = NUM_BUS - 1;

   initial begin
      if (NUM_BUS != 2) $fatal(1, "port list is built for two buses");
      if (RATIO_W < 5) $fatal(1, "ratio width cannot hold 16");
   end

   pcp_cfg_t                  cfg;
   code_t  [NUM_BUS-1:0]      bus_code;
   logic   [NUM_BUS-1:0]      bus_tick;
   logic   [NUM_BUS-1:0]      tmr_tick;

   pcp_cfg_regs #(.DATA_W(DATA_W)) i_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_wr_en),
      .wr_addr (cfg_wr_addr),
      .wr_data (cfg_wr_data),
      .cfg     (cfg)
   );

   assign bus_code[0] = cfg.bus1_code;
   assign bus_code[1] = cfg.bus2_code;

   for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
      pcp_div #(.RATIO_W(RATIO_W), .INIT_RATIO(1)) i_bus_div (
         .clk      (clk),
         .rst_n    (rst_n),
         .tick_in  (1'b1),
         .ratio_in (bus_ratio(bus_code[b])),
         .tick_out (bus_tick[b])
      );
      pcp_div #(.RATIO_W(RATIO_W), .INIT_RATIO(1)) i_tmr_div (
         .clk      (clk),
         .rst_n    (rst_n),
         .tick_in  (1'b1),
         .ratio_in (tmr_ratio(bus_code[b])),
         .tick_out (tmr_tick[b])
      );
   end

   pcp_div #(.RATIO_W(RATIO_W), .INIT_RATIO(2)) i_adc_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_in  (bus_tick[ADC_BUS]),
      .ratio_in (adc_ratio(cfg.adc_code)),
      .tick_out (adc_en)
   );

   pcp_div #(.RATIO_W(RATIO_W), .INIT_RATIO(8)) i_tick_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_in  (1'b1),
      .ratio_in (tick_ratio(cfg.tick_full)),
      .tick_out (tick_en)
   );

   assign bus1_en = bus_tick[0];
   assign bus2_en = bus_tick[1];
   assign tmr1_en = tmr_tick[0];
   assign tmr2_en = tmr_tick[1];

endmodule

// File: rtl/pcp_checker.sv
module pcp_checker (
   input logic clk,
   input logic rst_n,
   input logic bus1_en,
   input logic bus2_en,
   input logic tmr1_en,
   input logic tmr2_en,
   input logic adc_en,
   input logic tick_en
);

   logic [8:0] gap_b1, gap_b2, gap_t1, gap_t2, gap_tk, gap_adc;
   logic       seen_b1, seen_b2, seen_t1, seen_t2, seen_tk, seen_adc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_b1 <= '0; gap_b2 <= '0; gap_t1 <= '0; gap_t2 <= '0; gap_tk <= '0; gap_adc <= '0;
         seen_b1 <= 1'b0; seen_b2 <= 1'b0; seen_t1 <= 1'b0; seen_t2 <= 1'b0;
         seen_tk <= 1'b0; seen_adc <= 1'b0;
      end else begin
         gap_b1 <= bus1_en ? 9'd1 : (gap_b1 + 9'd1);
         gap_b2 <= bus2_en ? 9'd1 : (gap_b2 + 9'd1);
         gap_t1 <= tmr1_en ? 9'd1 : (gap_t1 + 9'd1);
         gap_t2 <= tmr2_en ? 9'd1 : (gap_t2 + 9'd1);
         gap_tk <= tick_en ? 9'd1 : (gap_tk + 9'd1);
         if (adc_en)       gap_adc <= 9'd1;
         else if (bus2_en) gap_adc <= gap_adc + 9'd1;
         seen_b1  <= seen_b1  | bus1_en;
         seen_b2  <= seen_b2  | bus2_en;
         seen_t1  <= seen_t1  | tmr1_en;
         seen_t2  <= seen_t2  | tmr2_en;
         seen_tk  <= seen_tk  | tick_en;
         seen_adc <= seen_adc | adc_en;
      end
   end

   always_comb begin
      if (!rst_n) begin
         AST_QUIET_IN_RESET: assert (!(bus1_en | bus2_en | tmr1_en | tmr2_en | adc_en | tick_en)); // R8
      end
   end

   AST_BUS1_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus1_en && seen_b1) |-> ($countones(gap_b1) == 1 && gap_b1 <= 9'd16)); // R2
   AST_BUS2_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus2_en && seen_b2) |-> ($countones(gap_b2) == 1 && gap_b2 <= 9'd16)); // R2
   AST_TMR1_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr1_en && seen_t1) |-> ($countones(gap_t1) == 1 && gap_t1 <= 9'd8)); // R4
   AST_TMR2_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr2_en && seen_t2) |-> ($countones(gap_t2) == 1 && gap_t2 <= 9'd8)); // R4
   AST_ADC_ON_BUS2: assert property (@(posedge clk) disable iff (!rst_n)
      adc_en |-> bus2_en); // R5
   AST_ADC_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      (adc_en && seen_adc) |-> (gap_adc inside {9'd2, 9'd4, 9'd6, 9'd8, 9'd12, 9'd16})); // R5
   AST_TICK_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && seen_tk) |-> (gap_tk == 9'd1 || gap_tk == 9'd8)); // R6

endmodule

bind periph_clk_prescaler pcp_checker i_chk (.*);

// File: tb/test_periph_clk_prescaler.sv
module test_periph_clk_prescaler;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_wr_en = 1'b0;
   logic       cfg_wr_addr = 1'b0;
   logic [7:0] cfg_wr_data = '0;
   logic bus1_en, bus2_en, tmr1_en, tmr2_en, adc_en, tick_en;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   periph_clk_prescaler i_periph_clk_prescaler (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
      .cfg_wr_data(cfg_wr_data), .bus1_en(bus1_en), .bus2_en(bus2_en),
      .tmr1_en(tmr1_en), .tmr2_en(tmr2_en), .adc_en(adc_en), .tick_en(tick_en)
   );

   function automatic int exp_bus(int c);
      return (c >= 4) ? 16 : (1 << c);
   endfunction
   function automatic int exp_tmr(int c);
      return (exp_bus(c) == 1) ? 1 : exp_bus(c) / 2;
   endfunction
   function automatic int exp_adc(int c);
      case (c)
         0: return 2;   1: return 4;   2: return 6;
         3: return 8;   4: return 12;  default: return 16;
      endcase
   endfunction

   function automatic logic pick(int s);
      case (s)
         0: return bus1_en;  1: return bus2_en;  2: return tmr1_en;
         3: return tmr2_en;  4: return adc_en;   default: return tick_en;
      endcase
   endfunction

   task automatic check(bit ok, string tag, int act, int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
      end
   endtask

   task automatic wr(logic a, logic [7:0] d);
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d;
      @(negedge clk);
      cfg_wr_en = 1'b0;
   endtask

   task automatic wait_pulse(int s);
      int guard = 0;
      do begin @(negedge clk); guard++; end while (!pick(s) && guard < 2000);
   endtask

   // time n intervals of output s, each expected to last expv cycles
   task automatic measure(int s, int expv, int n, string tag);
      wait_pulse(s);
      for (int i = 0; i < n; i++) begin
         int gap = 0;
         do begin @(negedge clk); gap++; end while (!pick(s) && gap < 2000);
         check(gap == expv, tag, gap, expv);
      end
   endtask

   task automatic run_cfg(int c1, int c2, int ca, int tf, logic [1:0] junk);
      wr(1'b0, {junk, 3'(c2), 3'(c1)});
      wr(1'b1, {junk, 1'b0, tf[0], 3'(ca)});
      repeat (560) @(negedge clk);
      measure(0, exp_bus(c1), 2, "R1/R2 bus1");
      measure(1, exp_bus(c2), 2, "R1/R2 bus2");
      measure(2, exp_tmr(c1), 2, (exp_bus(c1) == 1) ? "R3 tmr1" : "R4 tmr1");
      measure(3, exp_tmr(c2), 2, (exp_bus(c2) == 1) ? "R3 tmr2" : "R4 tmr2");
      measure(4, exp_adc(ca) * exp_bus(c2), 2, "R5 adc");
      measure(5, tf ? 1 : 8, 2, "R6 tick");
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      // R8: quiet while in reset
      check({bus1_en, bus2_en, tmr1_en, tmr2_en, adc_en, tick_en} == 6'b0,
            "R8 reset outputs", {bus1_en, bus2_en, tmr1_en, tmr2_en, adc_en, tick_en}, 0);
      rst_n = 1'b1;
      // R8: default periods
      measure(0, 1, 3, "R8 bus1 default");
      measure(3, 1, 3, "R8/R3 tmr2 default");
      measure(4, 2, 3, "R8 adc default");
      measure(5, 8, 3, "R8 tick default");

      // directed extremes
      run_cfg(4, 4, 5, 1, 2'b11);       // longest adc: 256
      run_cfg(7, 5, 6, 0, 2'b00);       // aliasing codes
      run_cfg(1, 2, 7, 1, 2'b01);
      run_cfg(0, 3, 4, 0, 2'b10);

      // R7: write mid interval, old length must complete
      wr(1'b0, 8'h04);                  // bus1 /16
      repeat (40) @(negedge clk);
      wait_pulse(0);
      begin
         int gap = 0;
         repeat (3) begin @(negedge clk); gap++; end
         cfg_wr_en = 1'b1; cfg_wr_addr = 1'b0; cfg_wr_data = 8'h00;
         @(negedge clk); gap++;
         cfg_wr_en = 1'b0;
         while (!bus1_en && gap < 2000) begin @(negedge clk); gap++; end
         check(gap == 16, "R7 old interval kept", gap, 16);
         gap = 0;
         do begin @(negedge clk); gap++; end while (!bus1_en && gap < 2000);
         check(gap == 1, "R7 new interval", gap, 1);
      end
      wr(1'b1, 8'h08);                  // tick full rate
      repeat (20) @(negedge clk);
      wait_pulse(5);
      wr(1'b1, 8'h00);                  // back to /8 after a pulse
      measure(5, 8, 2, "R7 tick slows");

      // constrained random
      for (int it = 0; it < 24; it++) begin
         run_cfg($urandom_range(7), $urandom_range(7), $urandom_range(7),
                 $urandom_range(1), 2'($urandom_range(3)));
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule